// File: doc/BRIEF.md
# Four-Phase Handshake Sequencing Controller

This block couples an upstream four-phase channel to a downstream one. An upstream requester raises its request. The controller passes that request on downstream and waits for the downstream acknowledge. It then retires the downstream request. Only after the upstream request falls and the downstream acknowledge falls does it signal completion upstream. Each step waits for a single handshake edge and answers it with a single output edge. The four steps form a fixed ring.

The model is synchronous. Both handshake inputs cross into the clock domain through a configurable synchroniser chain before edge detection. The two outputs come straight from flip-flops, so they cannot glitch. Any edge that the current step does not expect is ignored. Such an edge also sets a sticky protocol-error flag, which only reset clears. The environment is assumed to wait until the controller has answered one edge before it presents the next.

Top module: `hs_seq_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, the controller returns to the idle step. After that edge `b_req_o`=0, `a_ack_o`=1 and `proto_err_o`=0.
- R2: In the idle step (upstream request and downstream acknowledge both low), a rising `a_req_i` drives `b_req_o` to 1 and moves the controller to the forward step.
- R3: In the forward step, a rising `b_ack_i` drives `b_req_o` to 0 and moves the controller to the drain step.
- R4: In the drain step, a falling `a_req_i` drives `a_ack_o` to 0 and moves the controller to the re-arm step.
- R5: In the re-arm step, a falling `b_ack_i` drives `a_ack_o` to 1 and returns the controller to the idle step. A new handshake can start at once.
- R6: An input change first shows at the outputs after the (SYNC_STAGES+1)-th rising clock edge following it, which is the 3rd edge by default. The outputs keep their old values before that edge.
- R7: An edge on an input that the current step does not expect sets `proto_err_o` to 1 and leaves `b_req_o`, `a_ack_o` and the step unchanged.
- R8: Once `proto_err_o` is 1 it stays 1 until reset. Legal handshakes that follow are still processed normally.
- R9: `b_req_o` and `a_ack_o` never change on the same clock edge.
- R10: With no edge on either input, the step and both outputs hold their values indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_req_i | input | 1 | Upstream request, asynchronous level |
| a_ack_o | output | 1 | Upstream acknowledge, registered |
| b_req_o | output | 1 | Downstream request, registered |
| b_ack_i | input | 1 | Downstream acknowledge, asynchronous level |
| proto_err_o | output | 1 | Sticky flag: an unexpected handshake edge was seen |

## Verification
A corrupted step register shows up as a wrong output level, or as a legal edge that gets flagged as an error. This appears within SYNC_STAGES+1 cycles of the next input edge. The bench therefore walks into each of the four steps and applies both the expected and the unexpected input toggle there. It checks the outputs one cycle before and at the cycle where they should move, so a wrong latency is caught as well as a wrong level. A step that drifts while the inputs are idle is caught by a long hold with no edges.

// File: rtl/hs_seq_pkg.sv
package hs_seq_pkg;

    // Ring position of the controller; order is the handshake sequence
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for upstream request to rise
        ST_FWD   = 2'd1,   // downstream request up, waiting for its ack to rise
        ST_DRAIN = 2'd2,   // waiting for upstream request to fall
        ST_REARM = 2'd3    // upstream ack low, waiting for downstream ack to fall
    } ring_st_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    typedef struct packed {
        edge_t a_req;
        edge_t b_ack;
    } edge_bundle_t;

    localparam logic RST_B_REQ = 1'b0;
    localparam logic RST_A_ACK = 1'b1;

    function automatic ring_st_t ring_next(input ring_st_t s);
        logic [1:0] nxt;
        nxt = s + 2'd1;
        return ring_st_t'(nxt);
    endfunction

    // True when the edge the current position waits for is present
    function automatic logic expected_edge(input ring_st_t s, input edge_bundle_t e);
        logic hit;
        case (s)
            ST_IDLE:  hit = e.a_req.rise;
            ST_FWD:   hit = e.b_ack.rise;
            ST_DRAIN: hit = e.a_req.fall;
            default:  hit = e.b_ack.fall;
        endcase
        return hit;
    endfunction

    function automatic logic any_edge(input edge_bundle_t e);
        return e.a_req.rise | e.a_req.fall | e.b_ack.rise | e.b_ack.fall;
    endfunction

    function automatic logic b_req_level(input ring_st_t s);
        return s == ST_FWD;
    endfunction

    function automatic logic a_ack_level(input ring_st_t s);
        return s != ST_REARM;
    endfunction

endpackage

// File: rtl/hs_sync_edge.sv
module hs_sync_edge #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 din,
    output hs_seq_pkg::edge_t    ev
);
    localparam int DEPTH = STAGES + 1;

    // chain[STAGES-1] is the settled level, chain[STAGES] its previous value
    logic [DEPTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {DEPTH{RST_VAL}};
        else     chain <= {chain[DEPTH-2:0], din};
    end

    assign ev.rise =  chain[STAGES-1] & ~chain[STAGES];
    assign ev.fall = ~chain[STAGES-1] &  chain[STAGES];

endmodule

// File: rtl/hs_ring_fsm.sv
module hs_ring_fsm
    import hs_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  edge_bundle_t  ev,
    output ring_st_t      st_o,
    output logic          b_req_o,
    output logic          a_ack_o
);
    ring_st_t st_q, st_d;
    logic     adv;
    logic     b_req_q, a_ack_q;

    assign adv = expected_edge(st_q, ev);

    always_comb begin
        st_d = st_q;
        if (adv) st_d = ring_next(st_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            b_req_q <= RST_B_REQ;
            a_ack_q <= RST_A_ACK;
        end else begin
            st_q    <= st_d;
            b_req_q <= b_req_level(st_d);
            a_ack_q <= a_ack_level(st_d);
        end
    end

    assign st_o    = st_q;
    assign b_req_o = b_req_q;
    assign a_ack_o = a_ack_q;

    a_r1_reset_levels: assert property (@(posedge clk)
        rst |=> (st_q == ST_IDLE && !b_req_q && a_ack_q));

    a_r2_forward_req: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && ev.a_req.rise) |=> (b_req_q && st_q == ST_FWD));

    a_r3_retire_req: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FWD && ev.b_ack.rise) |=> (!b_req_q && st_q == ST_DRAIN));

    a_r4_drop_ack: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DRAIN && ev.a_req.fall) |=> (!a_ack_q && st_q == ST_REARM));

    a_r5_restore_ack: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_REARM && ev.b_ack.fall) |=> (a_ack_q && st_q == ST_IDLE));

    a_r7_ignore_stray: assert property (@(posedge clk) disable iff (rst)
        (any_edge(ev) && !adv) |=> ($stable(st_q) && $stable(b_req_q) && $stable(a_ack_q)));

    a_r9_one_output_moves: assert property (@(posedge clk) disable iff (rst)
        !$stable(b_req_q) |-> $stable(a_ack_q));

    a_r10_hold_idle_inputs: assert property (@(posedge clk) disable iff (rst)
        !any_edge(ev) |=> ($stable(st_q) && $stable(b_req_q) && $stable(a_ack_q)));

endmodule

// File: rtl/hs_fault_latch.sv
module hs_fault_latch
    import hs_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  ring_st_t      st,
    input  edge_bundle_t  ev,
    output logic          err_o
);
    logic err_q;
    logic stray;

    assign stray = any_edge(ev) & ~expected_edge(st, ev);

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= err_q | stray;
    end

    assign err_o = err_q;

    a_r7_idle_ack_stray: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && (ev.b_ack.rise || ev.b_ack.fall)) |=> err_q);

    a_r7_fwd_req_stray: assert property (@(posedge clk) disable iff (rst)
        (st == ST_FWD && ev.a_req.fall) |=> err_q);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/hs_seq_ctrl.sv
module hs_seq_ctrl
    import hs_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic a_req_i,
    output logic a_ack_o,
    output logic b_req_o,
    input  logic b_ack_i,
    output logic proto_err_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    edge_t           ch_ev [N_IN];
    edge_bundle_t    ev;
    ring_st_t        st;

    assign raw_in = {b_ack_i, a_req_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        hs_sync_edge #(
            .STAGES  (SYNC_STAGES),
            .RST_VAL (1'b0)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw_in[g]),
            .ev  (ch_ev[g])
        );
    end

    assign ev.a_req = ch_ev[0];
    assign ev.b_ack = ch_ev[1];

    hs_ring_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .st_o    (st),
        .b_req_o (b_req_o),
        .a_ack_o (a_ack_o)
    );

    hs_fault_latch u_err (
        .clk   (clk),
        .rst   (rst),
        .st    (st),
        .ev    (ev),
        .err_o (proto_err_o)
    );

endmodule

// File: tb/tb_hs_seq_ctrl.sv
`timescale 1ns/1ps
module tb_hs_seq_ctrl;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_req = 1'b0;
    logic b_ack = 1'b0;
    logic a_ack, b_req, perr;

    int checks = 0;
    int fails  = 0;
    int ms     = 0;      // model ring position 0..3
    bit m_err  = 1'b0;
    int sim_viol = 0;
    logic prev_b, prev_a;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    hs_seq_ctrl #(.SYNC_STAGES(SYNC)) dut (
        .clk(clk), .rst(rst), .a_req_i(a_req), .a_ack_o(a_ack),
        .b_req_o(b_req), .b_ack_i(b_ack), .proto_err_o(perr)
    );

    task automatic check3(input string tag, input logic eb, input logic ea, input logic ee);
        checks++;
        if (b_req !== eb || a_ack !== ea || perr !== ee) begin
            fails++;
            $display("FAIL %s: b_req/a_ack/err = %b%b%b expected %b%b%b",
                     tag, b_req, a_ack, perr, eb, ea, ee);
        end
    endtask

    function automatic logic exp_breq(input int s); return s == 1; endfunction
    function automatic logic exp_aack(input int s); return s != 3; endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; a_req = 1'b0; b_ack = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ms = 0; m_err = 1'b0;
        check3("R1 reset", 1'b0, 1'b1, 1'b0);
    endtask

    // toggle one input and check latency and the response
    task automatic toggle(input bit on_ba);
        bit legal;
        string tag;
        logic ob, oa, oe;
        legal = (on_ba == (ms % 2 == 1));
        case (ms)
            0: tag = "R2";
            1: tag = "R3";
            2: tag = "R4";
            default: tag = "R5";
        endcase
        if (!legal) tag = "R7";
        ob = exp_breq(ms); oa = exp_aack(ms); oe = m_err;
        @(negedge clk);
        if (on_ba) b_ack = ~b_ack; else a_req = ~a_req;
        repeat (SYNC) @(posedge clk);
        @(negedge clk);
        check3("R6 no early response", ob, oa, oe);
        if (legal) ms = (ms + 1) % 4; else m_err = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check3(tag, exp_breq(ms), exp_aack(ms), m_err);
    endtask

    always @(negedge clk) begin
        if (rst) begin
            prev_b <= b_req; prev_a <= a_ack;
        end else begin
            if (b_req !== prev_b && a_ack !== prev_a) sim_viol++;
            prev_b <= b_req; prev_a <= a_ack;
        end
    end

    initial begin
        // sweep: every ring position, both possible input toggles
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 2; b++) begin
                do_reset();
                for (int k = 0; k < s; k++) toggle(k % 2 == 1);
                toggle(b == 1);
            end
        end

        // R5: back-to-back full handshakes
        do_reset();
        for (int c = 0; c < 3; c++)
            for (int k = 0; k < 4; k++) toggle(k % 2 == 1);
        checks++;
        if (ms != 0) begin fails++; $display("FAIL R5: ring pos %0d expected 0", ms); end

        // R8: stray edges, then a legal cycle keeps working with flag held
        do_reset();
        toggle(1'b1);
        toggle(1'b1);
        for (int k = 0; k < 4; k++) toggle(k % 2 == 1);
        check3("R8 sticky after cycle", 1'b0, 1'b1, 1'b1);

        // R10: hold in forward step with no input activity
        do_reset();
        toggle(1'b0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check3("R10 hold", 1'b1, 1'b1, 1'b0);

        // R9: never both outputs moving on one edge
        checks++;
        if (sim_viol != 0) begin
            fails++;
            $display("FAIL R9: simultaneous changes %0d expected 0", sim_viol);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule